// File: doc/BRIEF.md
# DDR Access Scheduler with Row-Hit Chaining

This block sits between the user-side request queues of a DDR memory controller and an abstract memory command port. It drains a write-address queue and a write-data queue, which supplies one rising word, one falling word and one byte-enable mask per beat. It also drains a read-address queue. Each access moves four 32-bit words as two double-data-rate beats. Read results go back to the user read queues as rising/falling word pairs.

Between accesses, the scheduler looks at the head of each queue and chooses whether to read or to write. When both directions are ready, it alternates between them. When the chosen address falls in the row that is already open, the next pair of beats follows the current one with no gap. Otherwise the row is closed and the new row is opened. The row is also closed when there is no more work. A refresh request is served only between accesses, and only once the row is closed.

The block keeps a 32-bit occupancy count of completed accesses. The count rises on each completed write, falls on each completed read, and has its own asynchronous clear.

Top module: `ddrsch_top`

## Requirements
- R1: A write access issues two consecutive write beats. Beat k carries column base+2k, with the rising word at that column and the falling word at the next column. Each beat consumes one write-data entry. Mask bit i (i=0..3) set disables byte i of the falling word; mask bit 4+i set disables byte i of the rising word.
- R2: A read access issues two consecutive read beats. The cycle after each read beat, `rdPush` is high and `rdRise`/`rdFall` carry the words read at the beat's column and the next column, in the order rise, fall, rise, fall.
- R3: When an access ends and the next chosen access has the same row (address bits 24..10), the next first beat is issued in the cycle right after the current last beat, with no close or open command.
- R4: On a row mismatch, a close command follows the last beat. The first beat of the next access then comes exactly CLOSE_LAT+OPEN_LAT+1 cycles after the previous last beat.
- R5: When no access is ready at the end of an access, a close command is issued in the very next cycle.
- R6: When both directions are ready, the started accesses alternate between write and read. After reset, a write is preferred first. At most one address is popped per cycle.
- R7: No read access is started, and the read-address queue is not popped, while `rdSpace` is low.
- R8: `occCount` resets to 0. It increases by one per completed write access and decreases by one per completed read access, wrapping modulo 2^32 in both directions.
- R9: `cntRstN` low clears `occCount` asynchronously, without waiting for a clock edge.
- R10: A refresh command is issued only between accesses, after the open row has been closed. `refAck` is high in the cycle the refresh command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous-domain active-low reset of the scheduler |
| cntRstN | input | 1 | Asynchronous active-low clear of the occupancy count |
| wrAddrValid | input | 1 | Write-address queue not empty |
| wrAddr | input | 25 | Head of write-address queue |
| wrAddrPop | output | 1 | Consume the write-address head |
| wrRise | input | 32 | Head rising word of write-data queue |
| wrFall | input | 32 | Head falling word of write-data queue |
| wrMask | input | 8 | Head byte-disable mask of write-data queue |
| wrDataPop | output | 1 | Consume the write-data head |
| rdAddrValid | input | 1 | Read-address queue not empty |
| rdAddr | input | 25 | Head of read-address queue |
| rdAddrPop | output | 1 | Consume the read-address head |
| rdSpace | input | 1 | Read-data queues can take one full access |
| rdPush | output | 1 | Write a word pair into the read-data queues |
| rdRise | output | 32 | Rising word returned |
| rdFall | output | 32 | Falling word returned |
| refReq | input | 1 | Refresh wanted |
| refAck | output | 1 | Refresh command issued this cycle |
| memCmd | output | 3 | Command: 0 none, 1 open, 2 close, 3 read beat, 4 write beat, 5 refresh |
| memRow | output | 15 | Row of the command |
| memCol | output | 10 | Column of the beat |
| memWrRise | output | 32 | Rising write word of the beat |
| memWrFall | output | 32 | Falling write word of the beat |
| memWrMask | output | 8 | Byte-disable mask of the beat |
| memRdRise | input | 32 | Word read at `memCol` |
| memRdFall | input | 32 | Word read at `memCol`+1 |
| occCount | output | 32 | Completed-access occupancy count |

## Verification
The first stimulus is a single masked write, which checks byte enables and the automatic close on an idle queue. A three-write sequence follows: two same-row addresses and then a new row. It tells back-to-back chaining apart from the exact close-plus-open gap. Mixed reads and writes to one row show whether the scheduler alternates, and whether read data returns from the locations just written. Three further cases cover a read held back by a full read queue, a refresh raised during a burst, and a read on a zero count that must wrap the occupancy count down before a write wraps it back up.

// File: rtl/ddrsch_pkg.sv
package ddrsch_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_OPEN    = 3'd1,
    CMD_CLOSE   = 3'd2,
    CMD_READ    = 3'd3,
    CMD_WRITE   = 3'd4,
    CMD_REFRESH = 3'd5
  } memCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;       // latch the chosen address
    logic commitWrite;  // chosen access is a write
    logic beatRead;
    logic beatWrite;
    logic beatIdx;      // 0 first beat, 1 second beat
    logic doneWrite;
    logic doneRead;
  } ctlStrobe_t;

endpackage

// File: rtl/ddrsch_ctl.sv
module ddrsch_ctl
  import ddrsch_pkg::*;
#(
  parameter int ROW_W     = 15,
  parameter int OPEN_LAT  = 3,
  parameter int CLOSE_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrAddrValid,
  input  logic [ROW_W-1:0] wrRow,
  input  logic             rdAddrValid,
  input  logic [ROW_W-1:0] rdRow,
  input  logic             rdSpace,
  input  logic             refReq,
  output logic             wrAddrPop,
  output logic             rdAddrPop,
  output logic             refAck,
  output memCmd_e          memCmd,
  output ctlStrobe_t       strb
);

  localparam int MAX_LAT = (OPEN_LAT > CLOSE_LAT) ? OPEN_LAT : CLOSE_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);
  localparam logic [LAT_W-1:0] OPEN_END  = LAT_W'(OPEN_LAT - 1);
  localparam logic [LAT_W-1:0] CLOSE_END = LAT_W'(CLOSE_LAT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_OPEN, S_BEAT0, S_BEAT1, S_CLOSE, S_REFRESH
  } state_e;

  state_e           state, stateNxt;
  logic [LAT_W-1:0] latCnt;
  logic [ROW_W-1:0] openRow;
  logic             rowOpenQ;
  logic             curWrite;
  logic             lastWrite;

  logic             rdReady, wrReady, pickWrite, pickAny, rowHit, commit;
  logic [ROW_W-1:0] pickRow;

  // arbitration: alternate when both directions are ready
  always_comb begin
    rdReady   = rdAddrValid && rdSpace;
    wrReady   = wrAddrValid;
    pickWrite = wrReady && (!rdReady || !lastWrite);
    pickAny   = wrReady || rdReady;
    pickRow   = pickWrite ? wrRow : rdRow;
    rowHit    = pickAny && (pickRow == openRow);
  end

  always_comb begin
    stateNxt = state;
    commit   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (refReq) stateNxt = S_REFRESH;
        else if (pickAny) begin
          commit   = 1'b1;
          stateNxt = S_OPEN;
        end
      end
      S_OPEN:  if (latCnt == OPEN_END) stateNxt = S_BEAT0;
      S_BEAT0: stateNxt = S_BEAT1;
      S_BEAT1: begin
        if (!refReq && rowHit) begin
          commit   = 1'b1;
          stateNxt = S_BEAT0;
        end else begin
          stateNxt = S_CLOSE;
        end
      end
      S_CLOSE: begin
        if (latCnt == CLOSE_END) begin
          if (refReq) stateNxt = S_REFRESH;
          else if (pickAny) begin
            commit   = 1'b1;
            stateNxt = S_OPEN;
          end else stateNxt = S_IDLE;
        end
      end
      S_REFRESH: stateNxt = S_IDLE;
      default:   stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      latCnt    <= '0;
      openRow   <= '0;
      rowOpenQ  <= 1'b0;
      curWrite  <= 1'b0;
      lastWrite <= 1'b0;
    end else begin
      state  <= stateNxt;
      latCnt <= (stateNxt != state) ? '0 : latCnt + 1'b1;
      if (commit) begin
        openRow   <= pickRow;
        curWrite  <= pickWrite;
        lastWrite <= pickWrite;
      end
      if (state == S_OPEN && stateNxt == S_BEAT0) rowOpenQ <= 1'b1;
      else if (state == S_CLOSE)                   rowOpenQ <= 1'b0;
    end
  end

  always_comb begin
    memCmd = CMD_NOP;
    unique case (state)
      S_OPEN:    if (latCnt == '0) memCmd = CMD_OPEN;
      S_CLOSE:   if (latCnt == '0) memCmd = CMD_CLOSE;
      S_BEAT0,
      S_BEAT1:   memCmd = curWrite ? CMD_WRITE : CMD_READ;
      S_REFRESH: memCmd = CMD_REFRESH;
      default:   memCmd = CMD_NOP;
    endcase
  end

  always_comb begin
    wrAddrPop        = commit && pickWrite;
    rdAddrPop        = commit && !pickWrite;
    refAck           = (state == S_REFRESH);
    strb.commit      = commit;
    strb.commitWrite = pickWrite;
    strb.beatWrite   = (state == S_BEAT0 || state == S_BEAT1) && curWrite;
    strb.beatRead    = (state == S_BEAT0 || state == S_BEAT1) && !curWrite;
    strb.beatIdx     = (state == S_BEAT1);
    strb.doneWrite   = (state == S_BEAT1) && curWrite;
    strb.doneRead    = (state == S_BEAT1) && !curWrite;
  end

  AST_BEAT_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (memCmd == CMD_READ || memCmd == CMD_WRITE) |-> rowOpenQ); // R3
  AST_REFRESH_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (memCmd == CMD_REFRESH) |-> !rowOpenQ); // R10
  AST_READ_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrPop |-> rdSpace); // R7
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAddrPop && rdAddrPop)); // R6
  AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BEAT1 && !commit) |=> (memCmd == CMD_CLOSE)); // R5

endmodule

// File: rtl/ddrsch_dp.sv
module ddrsch_dp
  import ddrsch_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int ROW_W  = 15,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cntRstN,
  input  ctlStrobe_t              strb,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [DATA_W-1:0]       wrRise,
  input  logic [DATA_W-1:0]       wrFall,
  input  logic [DATA_W/4-1:0]     wrMask,
  input  logic [DATA_W-1:0]       memRdRise,
  input  logic [DATA_W-1:0]       memRdFall,
  output logic                    wrDataPop,
  output logic [ROW_W-1:0]        memRow,
  output logic [ADDR_W-ROW_W-1:0] memCol,
  output logic [DATA_W-1:0]       memWrRise,
  output logic [DATA_W-1:0]       memWrFall,
  output logic [DATA_W/4-1:0]     memWrMask,
  output logic                    rdPush,
  output logic [DATA_W-1:0]       rdRise,
  output logic [DATA_W-1:0]       rdFall,
  output logic [CNT_W-1:0]        occCount
);

  localparam int COL_W = ADDR_W - ROW_W;

  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk) begin
    if (!rstN) curAddr <= '0;
    else if (strb.commit) curAddr <= strb.commitWrite ? wrAddr : rdAddr;
  end

  assign memRow    = curAddr[ADDR_W-1:COL_W];
  assign memCol    = curAddr[COL_W-1:0] + (strb.beatIdx ? COL_W'(2) : COL_W'(0));
  assign memWrRise = wrRise;
  assign memWrFall = wrFall;
  assign memWrMask = wrMask;
  assign wrDataPop = strb.beatWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPush <= 1'b0;
      rdRise <= '0;
      rdFall <= '0;
    end else begin
      rdPush <= strb.beatRead;
      if (strb.beatRead) begin
        rdRise <= memRdRise;
        rdFall <= memRdFall;
      end
    end
  end

  always_ff @(posedge clk or negedge cntRstN) begin
    if (!cntRstN)            occCount <= '0;
    else if (strb.doneWrite) occCount <= occCount + 1'b1;
    else if (strb.doneRead)  occCount <= occCount - 1'b1;
  end

  AST_PUSH_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdPush |-> $past(strb.beatRead)); // R2
  AST_NO_DATA_POP_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatRead |-> !wrDataPop); // R1

endmodule

// File: rtl/ddrsch_top.sv
module ddrsch_top
  import ddrsch_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int ROW_W     = 15,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int OPEN_LAT  = 3,
  parameter int CLOSE_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cntRstN,
  input  logic                    wrAddrValid,
  input  logic [ADDR_W-1:0]       wrAddr,
  output logic                    wrAddrPop,
  input  logic [DATA_W-1:0]       wrRise,
  input  logic [DATA_W-1:0]       wrFall,
  input  logic [DATA_W/4-1:0]     wrMask,
  output logic                    wrDataPop,
  input  logic                    rdAddrValid,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic                    rdAddrPop,
  input  logic                    rdSpace,
  output logic                    rdPush,
  output logic [DATA_W-1:0]       rdRise,
  output logic [DATA_W-1:0]       rdFall,
  input  logic                    refReq,
  output logic                    refAck,
  output logic [2:0]              memCmd,
  output logic [ROW_W-1:0]        memRow,
  output logic [ADDR_W-ROW_W-1:0] memCol,
  output logic [DATA_W-1:0]       memWrRise,
  output logic [DATA_W-1:0]       memWrFall,
  output logic [DATA_W/4-1:0]     memWrMask,
  input  logic [DATA_W-1:0]       memRdRise,
  input  logic [DATA_W-1:0]       memRdFall,
  output logic [CNT_W-1:0]        occCount
);

  ctlStrobe_t strb;
  memCmd_e    cmdInt;

  ddrsch_ctl #(
    .ROW_W(ROW_W), .OPEN_LAT(OPEN_LAT), .CLOSE_LAT(CLOSE_LAT)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .wrAddrValid(wrAddrValid), .wrRow(wrAddr[ADDR_W-1:ADDR_W-ROW_W]),
    .rdAddrValid(rdAddrValid), .rdRow(rdAddr[ADDR_W-1:ADDR_W-ROW_W]),
    .rdSpace(rdSpace), .refReq(refReq),
    .wrAddrPop(wrAddrPop), .rdAddrPop(rdAddrPop), .refAck(refAck),
    .memCmd(cmdInt), .strb(strb)
  );

  ddrsch_dp #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cntRstN(cntRstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrRise(wrRise), .wrFall(wrFall), .wrMask(wrMask),
    .memRdRise(memRdRise), .memRdFall(memRdFall),
    .wrDataPop(wrDataPop), .memRow(memRow), .memCol(memCol),
    .memWrRise(memWrRise), .memWrFall(memWrFall), .memWrMask(memWrMask),
    .rdPush(rdPush), .rdRise(rdRise), .rdFall(rdFall), .occCount(occCount)
  );

  assign memCmd = cmdInt;

endmodule

// File: tb/ddrsch_top_bench.sv
module ddrsch_top_bench;
  import ddrsch_pkg::*;

  localparam int OPEN_LAT  = 3;
  localparam int CLOSE_LAT = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0, cntRstN = 1'b0;
  logic        wrAddrValid = 1'b0, rdAddrValid = 1'b0, rdSpace = 1'b1, refReq = 1'b0;
  logic [24:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrRise = '0, wrFall = '0;
  logic [7:0]  wrMask = '0;
  logic        wrAddrPop, wrDataPop, rdAddrPop, rdPush, refAck;
  logic [31:0] rdRise, rdFall, memWrRise, memWrFall, memRdRise, memRdFall, occCount;
  logic [2:0]  memCmd;
  logic [14:0] memRow;
  logic [9:0]  memCol;
  logic [7:0]  memWrMask;

  ddrsch_top #(.OPEN_LAT(OPEN_LAT), .CLOSE_LAT(CLOSE_LAT)) u_ddrsch_top (
    .clk(clk), .rstN(rstN), .cntRstN(cntRstN),
    .wrAddrValid(wrAddrValid), .wrAddr(wrAddr), .wrAddrPop(wrAddrPop),
    .wrRise(wrRise), .wrFall(wrFall), .wrMask(wrMask), .wrDataPop(wrDataPop),
    .rdAddrValid(rdAddrValid), .rdAddr(rdAddr), .rdAddrPop(rdAddrPop),
    .rdSpace(rdSpace), .rdPush(rdPush), .rdRise(rdRise), .rdFall(rdFall),
    .refReq(refReq), .refAck(refAck), .memCmd(memCmd), .memRow(memRow),
    .memCol(memCol), .memWrRise(memWrRise), .memWrFall(memWrFall),
    .memWrMask(memWrMask), .memRdRise(memRdRise), .memRdFall(memRdFall),
    .occCount(occCount)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural memory and shadow model
  logic [31:0] memArr [0:1023];
  logic [31:0] shadow [0:1023];
  function automatic int ix(input logic [14:0] r, input logic [9:0] c);
    return int'({r[3:0], c[5:0]});
  endfunction
  assign memRdRise = memArr[ix(memRow, memCol)];
  assign memRdFall = memArr[ix(memRow, memCol + 10'd1)];

  function automatic logic [31:0] applyMask(input logic [31:0] old, input logic [31:0] nw,
                                            input logic [3:0] dis);
    logic [31:0] res = old;
    for (int b = 0; b < 4; b++) if (!dis[b]) res[b*8 +: 8] = nw[b*8 +: 8];
    return res;
  endfunction

  // queues modelling the user FIFOs
  logic [24:0] waQ[$], raQ[$];
  logic [71:0] wdQ[$];
  logic [63:0] expQ[$];
  bit popWA, popWD, popRA;

  // logs of memory commands
  int beatCyc[$], beatWr[$], evCmd[$], evCyc[$];

  always @(negedge clk) begin
    cyc++;
    popWA = wrAddrPop; popWD = wrDataPop; popRA = rdAddrPop;
    if (rstN) begin
      if (memCmd == CMD_WRITE || memCmd == CMD_READ) begin
        beatCyc.push_back(cyc);
        beatWr.push_back(memCmd == CMD_WRITE ? 1 : 0);
      end else if (memCmd != CMD_NOP) begin
        evCmd.push_back(int'(memCmd));
        evCyc.push_back(cyc);
      end
      if (memCmd == CMD_WRITE) begin
        memArr[ix(memRow, memCol)] = applyMask(memArr[ix(memRow, memCol)], memWrRise, memWrMask[7:4]);
        memArr[ix(memRow, memCol + 10'd1)] = applyMask(memArr[ix(memRow, memCol + 10'd1)], memWrFall, memWrMask[3:0]);
      end
      // scoreboard monitor
      if (rdPush) begin
        if (expQ.size() == 0) chk(0, "R2", "unexpected read push", {rdFall, rdRise}, 64'h0);
        else begin
          logic [63:0] e;
          e = expQ.pop_front();
          chk({rdFall, rdRise} == e, "R2", "read pair", {rdFall, rdRise}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (popWA && waQ.size() > 0) void'(waQ.pop_front());
    if (popWD && wdQ.size() > 0) void'(wdQ.pop_front());
    if (popRA && raQ.size() > 0) void'(raQ.pop_front());
    popWA = 0; popWD = 0; popRA = 0;
    wrAddrValid = waQ.size() > 0;
    wrAddr      = (waQ.size() > 0) ? waQ[0] : '0;
    {wrMask, wrFall, wrRise} = (wdQ.size() > 0) ? wdQ[0] : '0;
    rdAddrValid = raQ.size() > 0;
    rdAddr      = (raQ.size() > 0) ? raQ[0] : '0;
  end

  // driver tasks
  task automatic pushWrite(input logic [14:0] r, input logic [9:0] c,
                           input logic [31:0] r0, f0, input logic [7:0] m0,
                           input logic [31:0] r1, f1, input logic [7:0] m1);
    waQ.push_back({r, c});
    wdQ.push_back({m0, f0, r0});
    wdQ.push_back({m1, f1, r1});
    shadow[ix(r, c)]       = applyMask(shadow[ix(r, c)], r0, m0[7:4]);
    shadow[ix(r, c + 1)]   = applyMask(shadow[ix(r, c + 1)], f0, m0[3:0]);
    shadow[ix(r, c + 2)]   = applyMask(shadow[ix(r, c + 2)], r1, m1[7:4]);
    shadow[ix(r, c + 3)]   = applyMask(shadow[ix(r, c + 3)], f1, m1[3:0]);
  endtask

  task automatic pushRead(input logic [14:0] r, input logic [9:0] c);
    raQ.push_back({r, c});
    expQ.push_back({shadow[ix(r, c + 1)], shadow[ix(r, c)]});
    expQ.push_back({shadow[ix(r, c + 3)], shadow[ix(r, c + 2)]});
  endtask

  task automatic clearLog();
    beatCyc.delete(); beatWr.delete(); evCmd.delete(); evCyc.delete();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin memArr[i] = '0; shadow[i] = '0; end
    repeat (4) @(negedge clk);
    chk(occCount == 0, "R8", "count during reset", occCount, 0);
    rstN = 1'b1; cntRstN = 1'b1;
    @(negedge clk);
    chk(memCmd == CMD_NOP && !wrAddrPop && !rdAddrPop, "R8", "idle after reset", memCmd, 0);
    chk(occCount == 0, "R8", "count after reset", occCount, 0);

    // T1: masked single write, auto close
    clearLog();
    pushWrite(15'd1, 10'd0, 32'hA0A0_0001, 32'hA0A0_0002, 8'h00,
                            32'hA0A0_0003, 32'hA0A0_0004, 8'h3F);
    repeat (20) @(negedge clk);
    chk(beatCyc.size() == 2 && beatWr[0] == 1 && beatCyc[1] == beatCyc[0] + 1, "R1", "two write beats", beatCyc.size(), 2);
    chk(memArr[ix(1, 0)] == 32'hA0A0_0001 && memArr[ix(1, 1)] == 32'hA0A0_0002, "R1", "first pair stored", memArr[ix(1, 1)], 32'hA0A0_0002);
    chk(memArr[ix(1, 2)] == 32'hA0A0_0000, "R1", "rise bytes 0,1 disabled", memArr[ix(1, 2)], 32'hA0A0_0000);
    chk(memArr[ix(1, 3)] == 32'h0, "R1", "fall word disabled", memArr[ix(1, 3)], 0);
    chk(evCmd.size() >= 2 && evCmd[1] == int'(CMD_CLOSE) && evCyc[1] == beatCyc[1] + 1, "R5", "close right after last beat", evCyc[1], beatCyc[1] + 1);
    chk(occCount == 1, "R8", "count after one write", occCount, 1);

    // T2: row hit chain then row miss
    clearLog();
    pushWrite(15'd2, 10'd0, 32'h1, 32'h2, 8'h0, 32'h3, 32'h4, 8'h0);
    pushWrite(15'd2, 10'd4, 32'h5, 32'h6, 8'h0, 32'h7, 32'h8, 8'h0);
    pushWrite(15'd3, 10'd0, 32'h9, 32'hA, 8'h0, 32'hB, 32'hC, 8'h0);
    repeat (40) @(negedge clk);
    chk(beatCyc.size() == 6, "R1", "six write beats", beatCyc.size(), 6);
    if (beatCyc.size() == 6) begin
      chk(beatCyc[2] == beatCyc[1] + 1 && beatCyc[3] == beatCyc[2] + 1, "R3", "row hit no gap", beatCyc[2] - beatCyc[1], 1);
      chk(beatCyc[4] - beatCyc[3] == CLOSE_LAT + OPEN_LAT + 1, "R4", "row miss gap", beatCyc[4] - beatCyc[3], CLOSE_LAT + OPEN_LAT + 1);
    end
    chk(evCmd.size() == 4 && evCmd[0] == int'(CMD_OPEN) && evCmd[1] == int'(CMD_CLOSE) && evCmd[2] == int'(CMD_OPEN), "R3", "one open per row", evCmd.size(), 4);
    chk(occCount == 4, "R8", "count after four writes", occCount, 4);

    // T3: chained reads
    clearLog();
    pushRead(15'd2, 10'd0);
    pushRead(15'd2, 10'd4);
    repeat (30) @(negedge clk);
    chk(beatCyc.size() == 4 && beatWr[0] == 0 && beatCyc[3] == beatCyc[0] + 3, "R2", "four chained read beats", beatCyc.size(), 4);
    chk(occCount == 2, "R8", "count after two reads", occCount, 2);

    // T4: alternation with both ready, same row
    clearLog();
    pushWrite(15'd4, 10'd0, 32'h41, 32'h42, 8'h0, 32'h43, 32'h44, 8'h0);
    pushWrite(15'd4, 10'd4, 32'h45, 32'h46, 8'h0, 32'h47, 32'h48, 8'h0);
    pushRead(15'd4, 10'd0);
    pushRead(15'd4, 10'd4);
    repeat (40) @(negedge clk);
    chk(beatCyc.size() == 8, "R6", "eight beats", beatCyc.size(), 8);
    if (beatCyc.size() == 8) begin
      int pat = 0;
      for (int i = 0; i < 8; i++) pat = (pat << 1) | beatWr[i];
      chk(pat == 8'b11001100, "R6", "write/read alternate", pat, 8'b11001100);
      chk(beatCyc[7] == beatCyc[0] + 7, "R3", "alternation stays chained", beatCyc[7] - beatCyc[0], 7);
    end

    // T5: read held off without space
    clearLog();
    rdSpace = 1'b0;
    pushRead(15'd3, 10'd0);
    repeat (20) @(negedge clk);
    chk(beatCyc.size() == 0 && raQ.size() == 1, "R7", "read held without space", beatCyc.size(), 0);
    rdSpace = 1'b1;
    repeat (20) @(negedge clk);
    chk(beatCyc.size() == 2 && raQ.size() == 0, "R7", "read runs once space returns", beatCyc.size(), 2);
    chk(occCount == 1, "R8", "count after read", occCount, 1);

    // T6: refresh during a chainable burst
    clearLog();
    pushWrite(15'd6, 10'd0, 32'h61, 32'h62, 8'h0, 32'h63, 32'h64, 8'h0);
    pushWrite(15'd6, 10'd4, 32'h65, 32'h66, 8'h0, 32'h67, 32'h68, 8'h0);
    while (memCmd != CMD_WRITE) @(negedge clk);
    refReq = 1'b1;
    while (!refAck) @(negedge clk);
    refReq = 1'b0;
    repeat (30) @(negedge clk);
    chk(evCmd.size() == 5 && evCmd[1] == int'(CMD_CLOSE) && evCmd[2] == int'(CMD_REFRESH), "R10", "close then refresh", evCmd.size(), 5);
    if (evCmd.size() == 5 && beatCyc.size() == 4) begin
      chk(evCyc[2] == beatCyc[1] + CLOSE_LAT + 1, "R10", "refresh after close", evCyc[2], beatCyc[1] + CLOSE_LAT + 1);
      chk(evCyc[2] < beatCyc[2], "R10", "refresh between accesses", evCyc[2], beatCyc[2]);
    end
    chk(occCount == 3, "R8", "count after refresh test", occCount, 3);

    // T7: asynchronous count clear
    @(negedge clk);
    #2 cntRstN = 1'b0;
    #1 chk(occCount == 0, "R9", "async clear", occCount, 0);
    #1 cntRstN = 1'b1;

    // T8: wrap down then up
    @(negedge clk);
    pushRead(15'd6, 10'd0);
    repeat (20) @(negedge clk);
    chk(occCount == 32'hFFFF_FFFF, "R8", "wrap below zero", occCount, 32'hFFFF_FFFF);
    pushWrite(15'd6, 10'd8, 32'h1, 32'h2, 8'h0, 32'h3, 32'h4, 8'h0);
    repeat (20) @(negedge clk);
    chk(occCount == 0, "R8", "wrap above all ones", occCount, 0);
    chk(expQ.size() == 0, "R2", "all reads returned", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule